// File: doc/BRIEF.md
# H-Bridge Channel Input Mode Decoder

This block converts the logic-level control inputs of a set of motor H-bridge channels into four gate commands per channel: a high-side and a low-side enable for leg A and for leg B. Channels are arranged in groups. One select input per group chooses how the two control inputs of every channel in that group are read. With the select low, they are an enable plus a phase. With the select high, they are two independent leg controls.

A per-channel brake input overrides the decoded command. A power-save input and two fault flags force every output open and take priority over brake. The fault flags are thermal shutdown and undervoltage lockout, both synchronous inputs.

Each leg passes through a break-before-make guard. Whenever a leg releases a drive level, the guard holds both of its switches off for a programmable number of clocks. Outputs are registered, so a command reaches the gates one clock edge after it is presented.

Top module: `hbd_mode_decoder`

## Requirements
- R1: With the group select low (enable/phase mode), `in_a` is the enable and `in_b` is the phase. Enable 0 turns all four switches of the channel off. Enable 1 with phase 1 drives forward: leg A high side on and leg B low side on. Enable 1 with phase 0 drives reverse: leg A low side on and leg B high side on.
- R2: With the group select high (two-input mode), `{in_a,in_b}` is decoded as follows: 00 opens all switches, 10 drives forward, 01 drives reverse, and 11 brakes.
- R3: `sel_inin[g]` governs channels g*CH_PER_GROUP through (g+1)*CH_PER_GROUP-1 and no others.
- R4: While power is on and no fault is flagged, `brake[c]` high forces channel c to brake regardless of `in_a`, `in_b` and the select. Brake means both low-side switches on and both high-side switches off.
- R5: `pwr_on` low turns every output off at the next rising edge, overriding brake.
- R6: `tsd_flag` or `uvlo_flag` high turns every output off at the next rising edge, overriding brake.
- R7: A command appears on the outputs at the first rising edge after it is presented, provided the affected leg is open and its dead-time wait has expired.
- R8: A leg that releases a drive level, whether toward the opposite level or toward open, keeps both switches off for at least `dead_time`+1 cycles. The count uses the `dead_time` value at the edge of release. If a level is still commanded when the wait ends, the leg drives it right after exactly `dead_time`+1 open cycles. A leg whose level does not change is not interrupted. The high and low sides of a leg are never on together.
- R9: Channels are independent: any combination of commands on different channels is carried out at the same time.
- R10: A synchronous active-low reset turns all outputs off and clears all dead-time counts, so the first command after reset takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_on | input | 1 | High for operation, low for standby (all open) |
| tsd_flag | input | 1 | Thermal shutdown flag, forces all open |
| uvlo_flag | input | 1 | Undervoltage lockout flag, forces all open |
| dead_time | input | DT_W (4) | Extra open cycles inserted when a leg releases a level |
| sel_inin | input | NUM_GROUPS (3) | Per-group mode: 0 enable/phase, 1 two-input |
| in_a | input | NUM_GROUPS*CH_PER_GROUP (6) | Per-channel first control input |
| in_b | input | NUM_GROUPS*CH_PER_GROUP (6) | Per-channel second control input |
| brake | input | NUM_GROUPS*CH_PER_GROUP (6) | Per-channel brake override |
| hs_a | output | NUM_GROUPS*CH_PER_GROUP (6) | Leg A high-side enable |
| ls_a | output | NUM_GROUPS*CH_PER_GROUP (6) | Leg A low-side enable |
| hs_b | output | NUM_GROUPS*CH_PER_GROUP (6) | Leg B high-side enable |
| ls_b | output | NUM_GROUPS*CH_PER_GROUP (6) | Leg B low-side enable |

## Verification
Directed passes visit every enable/phase and two-input code. Each code is held long enough that the dead-time wait completes, which separates an error in a decoding table from an error in the guard. A phase flip is run with a nonzero dead time and with zero dead time, so that an off-by-one in the open interval shows as a miscompare.

Two groups are then given opposite selects under identical inputs, which exposes a wrong group-to-channel mapping. Brake, standby and each fault flag are applied on top of driving commands, which checks their priority order. Long random runs follow, with changing dead times, held inputs and rare fault pulses. They mix leg reversals, releases to open and re-drives at the same level across all channels at once.

// File: rtl/hbd_pkg.sv
// Shared types for the H-bridge mode decoder.
// A leg is either open (both switches off), driven high or driven low.
package hbd_pkg;
    typedef enum logic [1:0] {
        LEG_OPEN = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2
    } leg_e;
endpackage

// File: rtl/hbd_chan_decode.sv
// Combinational command decoder for one H-bridge channel.
// Produces the wanted level of leg A and leg B from the two control
// inputs, the group mode select and the brake input.
// Assumes run_ok already folds standby and both fault flags; when it is
// low the channel is opened regardless of the other inputs.
module hbd_chan_decode
    import hbd_pkg::*;
(
    input  logic run_ok,
    input  logic sel_i,
    input  logic a_i,
    input  logic b_i,
    input  logic brake_i,
    output leg_e tgt_a,
    output leg_e tgt_b
);

    // Priority: standby/fault (R5, R6), then brake (R4), then mode decode (R1, R2).
    always_comb begin
        tgt_a = LEG_OPEN;
        tgt_b = LEG_OPEN;
        if (!run_ok) begin
            tgt_a = LEG_OPEN;
            tgt_b = LEG_OPEN;
        end else if (brake_i) begin
            tgt_a = LEG_LOW;
            tgt_b = LEG_LOW;
        end else if (!sel_i) begin
            // enable/phase: a_i enables, b_i picks direction
            if (a_i) begin
                tgt_a = b_i ? LEG_HIGH : LEG_LOW;
                tgt_b = b_i ? LEG_LOW  : LEG_HIGH;
            end
        end else begin
            // two-input: each input selects one direction, both means brake
            unique case ({a_i, b_i})
                2'b10: begin tgt_a = LEG_HIGH; tgt_b = LEG_LOW;  end
                2'b01: begin tgt_a = LEG_LOW;  tgt_b = LEG_HIGH; end
                2'b11: begin tgt_a = LEG_LOW;  tgt_b = LEG_LOW;  end
                default: begin tgt_a = LEG_OPEN; tgt_b = LEG_OPEN; end
            endcase
        end
    end

endmodule

// File: rtl/hbd_leg_guard.sv
// Break-before-make guard for one half-bridge leg.
// Holds the registered leg level. When the wanted level differs from
// the driven one, the leg opens and a counter loaded from dead_time
// must run down before any level is driven again.
// Assumes dead_time is quasi-static; the value at the release edge is used.
module hbd_leg_guard
    import hbd_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DT_W-1:0] dead_time,
    input  leg_e            tgt,
    output logic            hs_o,
    output logic            ls_o
);

    leg_e            cur_q;
    logic [DT_W-1:0] wait_q;

    // Leg state: release on change, count down while open, then take target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= LEG_OPEN;
            wait_q <= '0;
        end else if (cur_q != LEG_OPEN) begin
            if (tgt != cur_q) begin
                cur_q  <= LEG_OPEN;
                wait_q <= dead_time;
            end
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end else begin
            cur_q <= tgt;
        end
    end

    // Gate enables follow the registered leg level.
    always_comb begin
        hs_o = (cur_q == LEG_HIGH);
        ls_o = (cur_q == LEG_LOW);
    end

    // ---- checking support: measure the open gap seen at the pins ----
    logic            on_now;
    logic [DT_W:0]   gap_q;
    logic [DT_W-1:0] dt_at_release_q;
    logic            drove_q;

    assign on_now = hs_o | ls_o;

    // Track cycles spent open since the last drive and the dead time then in force.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q           <= '0;
            dt_at_release_q <= '0;
            drove_q         <= 1'b0;
        end else if (on_now) begin
            gap_q           <= '0;
            dt_at_release_q <= dead_time;
            drove_q         <= 1'b1;
        end else if (gap_q != {(DT_W+1){1'b1}}) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R8: a side that was on is never followed directly by the other side.
    a_r8_high_then_not_low: assert property (@(posedge clk) disable iff (!rst_n)
        hs_o |=> !ls_o);
    a_r8_low_then_not_high: assert property (@(posedge clk) disable iff (!rst_n)
        ls_o |=> !hs_o);

    // R8: re-driving after a release needs more than dead_time open cycles.
    a_r8_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (on_now && !$past(on_now) && drove_q) |-> (gap_q > {1'b0, dt_at_release_q}));

endmodule

// File: rtl/hbd_mode_decoder.sv
// Top of the H-bridge channel input mode decoder.
// Groups of CH_PER_GROUP channels share one mode select. Every channel
// has its own decoder and one guard per leg, so all channels act at
// once. Standby and the fault flags are combined once and fanned out.
// Assumes all inputs are synchronous to clk.
module hbd_mode_decoder
    import hbd_pkg::*;
#(
    parameter int NUM_GROUPS   = 3,
    parameter int CH_PER_GROUP = 2,
    parameter int DT_W         = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               pwr_on,
    input  logic                               tsd_flag,
    input  logic                               uvlo_flag,
    input  logic [DT_W-1:0]                    dead_time,
    input  logic [NUM_GROUPS-1:0]              sel_inin,
    input  logic [NUM_GROUPS*CH_PER_GROUP-1:0] in_a,
    input  logic [NUM_GROUPS*CH_PER_GROUP-1:0] in_b,
    input  logic [NUM_GROUPS*CH_PER_GROUP-1:0] brake,
    output logic [NUM_GROUPS*CH_PER_GROUP-1:0] hs_a,
    output logic [NUM_GROUPS*CH_PER_GROUP-1:0] ls_a,
    output logic [NUM_GROUPS*CH_PER_GROUP-1:0] hs_b,
    output logic [NUM_GROUPS*CH_PER_GROUP-1:0] ls_b
);

    localparam int NCH = NUM_GROUPS * CH_PER_GROUP;

    logic run_ok;

    // Operation allowed only when powered and no fault is flagged (R5, R6).
    always_comb begin
        run_ok = pwr_on && !tsd_flag && !uvlo_flag;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam int GRP = c / CH_PER_GROUP;
        leg_e tgt_a;
        leg_e tgt_b;

        hbd_chan_decode u_dec (
            .run_ok  (run_ok),
            .sel_i   (sel_inin[GRP]),
            .a_i     (in_a[c]),
            .b_i     (in_b[c]),
            .brake_i (brake[c]),
            .tgt_a   (tgt_a),
            .tgt_b   (tgt_b)
        );

        hbd_leg_guard #(.DT_W(DT_W)) u_leg_a (
            .clk       (clk),
            .rst_n     (rst_n),
            .dead_time (dead_time),
            .tgt       (tgt_a),
            .hs_o      (hs_a[c]),
            .ls_o      (ls_a[c])
        );

        hbd_leg_guard #(.DT_W(DT_W)) u_leg_b (
            .clk       (clk),
            .rst_n     (rst_n),
            .dead_time (dead_time),
            .tgt       (tgt_b),
            .hs_o      (hs_b[c]),
            .ls_o      (ls_b[c])
        );

        // R4: an active brake never turns on a high side.
        a_r4_brake_no_high: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_on && !tsd_flag && !uvlo_flag && brake[c]) |=> (!hs_a[c] && !hs_b[c]));

        // R1: enable low in enable/phase mode opens the channel.
        a_r1_enable_low_open: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_on && !tsd_flag && !uvlo_flag && !brake[c] && !sel_inin[GRP] && !in_a[c])
            |=> !(hs_a[c] || ls_a[c] || hs_b[c] || ls_b[c]));
    end

    // R5: standby opens every switch at the next edge.
    a_r5_standby_open: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> ((hs_a | ls_a | hs_b | ls_b) == '0));

    // R6: either fault flag opens every switch at the next edge.
    a_r6_fault_open: assert property (@(posedge clk) disable iff (!rst_n)
        (tsd_flag || uvlo_flag) |=> ((hs_a | ls_a | hs_b | ls_b) == '0));

endmodule

// File: tb/hbd_mode_decoder_bench.sv
// Self-checking bench: a per-leg model built from the requirements is
// stepped at every rising edge and compared at the falling edge.
module hbd_mode_decoder_bench;

    localparam int CLK_PERIOD   = 10;
    localparam int NUM_GROUPS   = 3;
    localparam int CH_PER_GROUP = 2;
    localparam int DT_W         = 4;
    localparam int NCH          = NUM_GROUPS * CH_PER_GROUP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_on = 1'b0;
    logic tsd_flag = 1'b0;
    logic uvlo_flag = 1'b0;
    logic [DT_W-1:0] dead_time = '0;
    logic [NUM_GROUPS-1:0] sel_inin = '0;
    logic [NCH-1:0] in_a = '0;
    logic [NCH-1:0] in_b = '0;
    logic [NCH-1:0] brake = '0;
    logic [NCH-1:0] hs_a, ls_a, hs_b, ls_b;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model: 0 open, 1 high, 2 low
    int m_cur [2*NCH];
    int m_cnt [2*NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    hbd_mode_decoder #(
        .NUM_GROUPS(NUM_GROUPS), .CH_PER_GROUP(CH_PER_GROUP), .DT_W(DT_W)
    ) u_hbd_mode_decoder (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .tsd_flag(tsd_flag),
        .uvlo_flag(uvlo_flag), .dead_time(dead_time), .sel_inin(sel_inin),
        .in_a(in_a), .in_b(in_b), .brake(brake),
        .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
    );

    // Wanted level of one leg from the requirement tables (R1, R2, R4, R5, R6).
    function automatic int want(int c, int leg);
        bit a, b, s;
        a = in_a[c];
        b = in_b[c];
        s = sel_inin[c / CH_PER_GROUP];
        if (!pwr_on || tsd_flag || uvlo_flag) return 0;
        if (brake[c]) return 2;
        if (!s) begin
            if (!a) return 0;
            if (b) return (leg == 0) ? 1 : 2;
            return (leg == 0) ? 2 : 1;
        end
        case ({a, b})
            2'b10:   return (leg == 0) ? 1 : 2;
            2'b01:   return (leg == 0) ? 2 : 1;
            2'b11:   return 2;
            default: return 0;
        endcase
    endfunction

    // One clock: advance the model at the edge, compare at the falling edge.
    task automatic step(string tag);
        logic [NCH-1:0] e_hs_a, e_ls_a, e_hs_b, e_ls_b;
        int t [2*NCH];
        @(posedge clk);
        for (int i = 0; i < 2*NCH; i++) t[i] = want(i / 2, i % 2);
        for (int i = 0; i < 2*NCH; i++) begin
            if (!rst_n) begin
                m_cur[i] = 0;
                m_cnt[i] = 0;
            end else if (m_cur[i] != 0) begin
                if (t[i] != m_cur[i]) begin
                    m_cur[i] = 0;
                    m_cnt[i] = int'(dead_time);
                end
            end else if (m_cnt[i] != 0) begin
                m_cnt[i] = m_cnt[i] - 1;
            end else begin
                m_cur[i] = t[i];
            end
        end
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            e_hs_a[c] = (m_cur[2*c] == 1);
            e_ls_a[c] = (m_cur[2*c] == 2);
            e_hs_b[c] = (m_cur[2*c+1] == 1);
            e_ls_b[c] = (m_cur[2*c+1] == 2);
        end
        n_vec++;
        if ({hs_a, ls_a, hs_b, ls_b} !== {e_hs_a, e_ls_a, e_hs_b, e_ls_b}) begin
            n_bad++;
            $display("FAIL %s hs_a/ls_a/hs_b/ls_b actual=%h/%h/%h/%h expected=%h/%h/%h/%h",
                     tag, hs_a, ls_a, hs_b, ls_b, e_hs_a, e_ls_a, e_hs_b, e_ls_b);
        end
    endtask

    task automatic steps(int n, string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    task automatic idle_inputs();
        pwr_on = 1'b1; tsd_flag = 1'b0; uvlo_flag = 1'b0;
        sel_inin = '0; in_a = '0; in_b = '0; brake = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int seed;
        int hold;
        seed = $urandom(32'h5EED_1234);
        for (int i = 0; i < 2*NCH; i++) begin m_cur[i] = 0; m_cnt[i] = 0; end

        // R10: reset with commands already present, outputs stay off
        pwr_on = 1'b1; in_a = '1; in_b = '1;
        steps(3, "R10");
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b1;
        // R10: first command after reset applies at the next edge
        in_a[0] = 1'b1; in_b[0] = 1'b1; dead_time = 4'd3;
        step("R10");
        // R7/R1: forward in enable/phase mode
        step("R7");
        // R8: phase flip reverses both legs through the dead time
        in_b[0] = 1'b0;
        steps(7, "R8");
        // R1: enable low opens the channel
        in_a[0] = 1'b0;
        steps(6, "R1");

        // R2: every two-input code on group 0
        sel_inin[0] = 1'b1;
        in_a[0] = 1'b1; in_b[0] = 1'b0; steps(6, "R2");
        in_a[0] = 1'b0; in_b[0] = 1'b1; steps(6, "R2");
        in_a[0] = 1'b1; in_b[0] = 1'b1; steps(6, "R2");
        in_a[0] = 1'b0; in_b[0] = 1'b0; steps(6, "R2");

        // R3: same inputs, groups in opposite modes
        sel_inin = 3'b010;
        in_a = 6'b001101; in_b = 6'b000000;
        steps(7, "R3");
        sel_inin = 3'b101;
        steps(7, "R3");

        // R4: brake over any inputs and modes
        brake = '1; in_a = 6'b101011; in_b = 6'b110101;
        steps(7, "R4");
        brake = '0;

        // R9: different commands on every channel at once
        sel_inin = 3'b110;
        in_a = 6'b011101; in_b = 6'b100110;
        steps(7, "R9");

        // R5: standby overrides brake and drive
        brake = 6'b000011;
        pwr_on = 1'b0; steps(3, "R5");
        pwr_on = 1'b1; steps(6, "R5");

        // R6: each fault flag opens all outputs
        tsd_flag = 1'b1; steps(3, "R6");
        tsd_flag = 1'b0; steps(6, "R6");
        uvlo_flag = 1'b1; steps(3, "R6");
        uvlo_flag = 1'b0; steps(6, "R6");

        // R8: zero dead time still leaves one open cycle on reversal
        idle_inputs();
        dead_time = 4'd0;
        in_a[1] = 1'b1; in_b[1] = 1'b1; steps(3, "R8");
        in_b[1] = 1'b0; steps(4, "R8");
        dead_time = 4'd15;
        in_b[1] = 1'b1; steps(20, "R8");

        // R9/R8: constrained random traffic
        for (int v = 0; v < 3000; v++) begin
            if (v % 97 == 0) dead_time = DT_W'($urandom_range(0, 6));
            if (v % 13 == 0) sel_inin = NUM_GROUPS'($urandom);
            in_a = NCH'($urandom);
            in_b = NCH'($urandom);
            brake = (($urandom % 8) == 0) ? NCH'($urandom) : '0;
            pwr_on = (($urandom % 40) != 0);
            tsd_flag = (($urandom % 60) == 0);
            uvlo_flag = (($urandom % 60) == 0);
            hold = $urandom_range(1, 8);
            steps(hold, "R9");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule